// File: doc/BRIEF.md
# Serial Command Register Port

This block is the host-facing slave of a subcode graphics decoder. A host drives
it over three wires plus an open-drain return line: a chip-enable that frames
each transfer, a serial clock, a data input and a data output that can only
pull low. Bits travel least significant first. Every transfer opens with an
address byte. The write address is followed by a control byte. Bit 0 of that
byte chooses between setting one of fourteen 8-bit configuration registers and
loading a 19-byte subcode packet. The read address starts a stream of one flag
byte and eighteen packet bytes that the decoder core supplies through an index
and data port.

The serial inputs are brought into the system clock domain through a short
synchroniser and sampled on the detected serial-clock edges. The system clock
must run at least eight times faster than the serial clock. A loaded packet
becomes visible to the core as a one-cycle strobe after chip-enable drops. The
host may stop a read at any byte boundary, and may read only the flag byte.

Top module: `sercmd_port`

## Requirements
- R1: With chip-enable high, the sequence address 0xF4, a control byte with bit 0 = 0 and the register number in bits 7:4, then a data byte (each byte sent bit 0 first on rising serial-clock edges) sets that register to the data byte. Register n appears at `cfg_regs[8n+7:8n]`.
- R2: After reset, register 0 holds 0x60 and registers 1 to 13 hold 0x00.
- R3: A register write that names register 14 or 15 leaves every register unchanged.
- R4: A transfer whose address byte is neither 0xF4 nor 0xF5 changes no register, makes no packet strobe and never pulls the data line low.
- R5: Address 0xF4 followed by a control byte with bit 0 = 1 starts a packet load. Bits 7:2 of the k-th following byte (k = 0 to 18) land in `pkt_data[6k+5:6k]`. When chip-enable falls after all 19 bytes, `pkt_wr` is high for exactly one cycle, and the buffer does not change while it is high.
- R6: A packet load ended with fewer than 19 bytes produces no strobe. Bytes beyond the nineteenth are ignored, and the first 19 are still committed.
- R7: After address 0xF5 the line presents the byte selected by `rd_idx` = 0 (the flag byte), then the bytes at indices 1 to 18 in order. Each byte goes out bit 0 first and changes after falling serial-clock edges. A low bit pulls the line low; a high bit releases it.
- R8: Once 19 bytes have been read, every further bit of the same transfer reads as 1 (line released).
- R9: The data line is released whenever chip-enable is low and throughout any write transfer. A read stopped at any byte boundary leaves the port ready for the next transfer, and the next read restarts at the flag byte.
- R10: In a register write, only the first byte after the control byte is stored. Later bytes in the same transfer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_ce | input | 1 | Chip-enable, high while a transfer is framed |
| ser_clk | input | 1 | Serial clock, data sampled on its rising edge |
| ser_din | input | 1 | Serial data from the host |
| ser_dout_low | output | 1 | 1 pulls the open-drain return line low, 0 releases it |
| cfg_regs | output | NUM_REGS*8 | Flattened configuration register file |
| pkt_data | output | PKT_BYTES*SYM_W | Flattened packet buffer, six subcode bits per byte |
| pkt_wr | output | 1 | One-cycle packet commit strobe |
| rd_idx | output | IDX_W | Index of the byte the core must place on rd_data |
| rd_data | input | 8 | Read byte from the decoder core for rd_idx |

## Verification
The bench builds the block with its default parameters: fourteen registers, a
19-byte packet, six symbol bits and a two-stage synchroniser. With a 4-bit
register select, register numbers 14 and 15 are reachable, so the ignored-write
path is exercised. The 19-byte packet length puts both the short-packet drop and
the surplus-byte cases within a few hundred serial bits. Reads of 21 bytes carry
the index past its last valid value, so the released-line tail can be observed.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_OFF,
        PH_ADDR,
        PH_CTRL,
        PH_REGDAT,
        PH_PKT,
        PH_READ,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic ce;
        logic sck_rise;
        logic sck_fall;
        logic din;
    } ser_ev_t;

    function automatic logic [BYTE_W-1:0] lsb_first_shift(
        input logic [BYTE_W-1:0] cur,
        input logic              bit_in
    );
        return {bit_in, cur[BYTE_W-1:1]};
    endfunction

endpackage

// File: rtl/sercmd_sync.sv
module sercmd_sync
    import sercmd_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    ce_raw,
    input  logic    sck_raw,
    input  logic    din_raw,
    output ser_ev_t ev
);

    logic [STAGES-1:0][2:0] stage_q;
    logic                   sck_prev_q;
    logic                   sck_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q    <= '0;
            sck_prev_q <= 1'b0;
        end else begin
            stage_q[0] <= {ce_raw, sck_raw, din_raw};
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
            sck_prev_q <= sck_s;
        end
    end

    assign sck_s       = stage_q[STAGES-1][1];
    assign ev.ce       = stage_q[STAGES-1][2];
    assign ev.din      = stage_q[STAGES-1][0];
    assign ev.sck_rise = sck_s & ~sck_prev_q;
    assign ev.sck_fall = ~sck_s & sck_prev_q;

endmodule

// File: rtl/sercmd_regfile.sv
module sercmd_regfile #(
    parameter int               NUM_REGS  = 14,
    parameter int               REG_W     = 8,
    parameter int               IDX_W     = 4,
    parameter logic [REG_W-1:0] REG0_INIT = 8'h60
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [REG_W-1:0]          wr_data,
    output logic [NUM_REGS*REG_W-1:0] regs_flat
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [REG_W-1:0] INIT = (g == 0) ? REG0_INIT : '0;
        logic [REG_W-1:0] r_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                r_q <= INIT;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                r_q <= wr_data;
            end
        end

        assign regs_flat[g*REG_W +: REG_W] = r_q;
    end

    // R3: no write strobe, no change anywhere in the file
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_flat))
        else $error("register file changed without a write");

    // R3: numbers past the file leave it untouched
    assert_oob_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (int'(wr_idx) >= NUM_REGS)) |=> $stable(regs_flat))
        else $error("out-of-range register number changed the file");

    // R2: reset value of register 0
    assert_init_R2: assert property (@(posedge clk)
        rst |=> (regs_flat[REG_W-1:0] == REG0_INIT))
        else $error("register 0 reset value wrong");

endmodule

// File: rtl/sercmd_pktbuf.sv
module sercmd_pktbuf #(
    parameter int PKT_BYTES = 19,
    parameter int SYM_W     = 6,
    parameter int CNT_W     = $clog2(PKT_BYTES + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic                       byte_we,
    input  logic [SYM_W-1:0]           sym_in,
    input  logic                       commit,
    output logic [PKT_BYTES*SYM_W-1:0] pkt_flat,
    output logic                       pkt_wr
);

    logic [CNT_W-1:0] cnt_q;
    logic             full;

    assign full = (cnt_q == CNT_W'(PKT_BYTES));

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt_q <= '0;
        end else if (byte_we && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar g = 0; g < PKT_BYTES; g++) begin : g_sym
        logic [SYM_W-1:0] sym_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sym_q <= '0;
            end else if (byte_we && (cnt_q == CNT_W'(g))) begin
                sym_q <= sym_in;
            end
        end

        assign pkt_flat[g*SYM_W +: SYM_W] = sym_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_wr <= 1'b0;
        end else begin
            pkt_wr <= commit && full;
        end
    end

    // R5: strobe lasts one cycle
    assert_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        pkt_wr |=> !pkt_wr)
        else $error("packet strobe longer than one cycle");

    // R5: buffer steady while the core takes it
    assert_steady_R5: assert property (@(posedge clk) disable iff (rst)
        pkt_wr |-> $stable(pkt_flat))
        else $error("packet buffer moved during commit");

endmodule

// File: rtl/sercmd_rdshift.sv
module sercmd_rdshift #(
    parameter int READ_BYTES = 19,
    parameter int IDX_W      = $clog2(READ_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load_first,
    input  logic             active,
    input  logic             sck_rise,
    input  logic             sck_fall,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             sdo_low
);

    logic [7:0]       sh_q;
    logic [3:0]       bits_q;
    logic [IDX_W-1:0] idx_q;
    logic             in_range;
    logic [7:0]       next_byte;

    assign in_range  = (idx_q < IDX_W'(READ_BYTES));
    assign next_byte = in_range ? rd_data : 8'hFF;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sh_q   <= 8'hFF;
            bits_q <= '0;
            idx_q  <= '0;
        end else if (load_first) begin
            sh_q   <= next_byte;
            bits_q <= '0;
            if (in_range) idx_q <= idx_q + 1'b1;
        end else if (active) begin
            if (sck_rise && (bits_q != 4'd8)) begin
                bits_q <= bits_q + 1'b1;
            end else if (sck_fall && (bits_q != 4'd0)) begin
                if (bits_q == 4'd8) begin
                    sh_q   <= next_byte;
                    bits_q <= '0;
                    if (in_range) idx_q <= idx_q + 1'b1;
                end else begin
                    sh_q <= {1'b1, sh_q[7:1]};
                end
            end
        end
    end

    assign rd_idx  = idx_q;
    assign sdo_low = active & ~sh_q[0];

    // R7: index only steps forward by one or restarts
    assert_step_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(idx_q) |-> ((idx_q == $past(idx_q) + 1'b1) || (idx_q == '0)))
        else $error("read index jumped");

    // R8: index never passes the end of the stream
    assert_bound_R8: assert property (@(posedge clk) disable iff (rst)
        int'(idx_q) <= READ_BYTES)
        else $error("read index beyond stream");

endmodule

// File: rtl/sercmd_port.sv
module sercmd_port
    import sercmd_pkg::*;
#(
    parameter int         NUM_REGS    = 14,
    parameter int         PKT_BYTES   = 19,
    parameter int         SYM_W       = 6,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] WR_ADDR     = 8'hF4,
    parameter logic [7:0] RD_ADDR     = 8'hF5,
    parameter logic [7:0] REG0_INIT   = 8'h60,
    localparam int        RSEL_W      = 4,
    localparam int        IDX_W       = $clog2(PKT_BYTES + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ser_ce,
    input  logic                         ser_clk,
    input  logic                         ser_din,
    output logic                         ser_dout_low,
    output logic [NUM_REGS*8-1:0]        cfg_regs,
    output logic [PKT_BYTES*SYM_W-1:0]   pkt_data,
    output logic                         pkt_wr,
    output logic [IDX_W-1:0]             rd_idx,
    input  logic [7:0]                   rd_data
);

    ser_ev_t           ev;
    phase_e            ph_q;
    logic              ce_q;
    logic [7:0]        sh_q;
    logic [2:0]        nb_q;
    logic [RSEL_W-1:0] rsel_q;

    logic              ce_rise;
    logic              ce_fall;
    logic              byte_done;
    logic [7:0]        byte_val;

    sercmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .ce_raw  (ser_ce),
        .sck_raw (ser_clk),
        .din_raw (ser_din),
        .ev      (ev)
    );

    assign ce_rise   = ev.ce & ~ce_q;
    assign ce_fall   = ~ev.ce & ce_q;
    assign byte_val  = lsb_first_shift(sh_q, ev.din);
    assign byte_done = ev.ce && (ph_q != PH_OFF) && ev.sck_rise && (nb_q == 3'd7);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_OFF;
            ce_q   <= 1'b0;
            sh_q   <= '0;
            nb_q   <= '0;
            rsel_q <= '0;
        end else begin
            ce_q <= ev.ce;
            if (ce_rise) begin
                ph_q <= PH_ADDR;
                nb_q <= '0;
            end else if (!ev.ce) begin
                ph_q <= PH_OFF;
            end else begin
                if (ev.sck_rise && (ph_q != PH_OFF)) begin
                    sh_q <= byte_val;
                    nb_q <= nb_q + 1'b1;
                end
                if (byte_done) begin
                    case (ph_q)
                        PH_ADDR: begin
                            if (byte_val == WR_ADDR)      ph_q <= PH_CTRL;
                            else if (byte_val == RD_ADDR) ph_q <= PH_READ;
                            else                          ph_q <= PH_SKIP;
                        end
                        PH_CTRL: begin
                            if (byte_val[0]) begin
                                ph_q <= PH_PKT;
                            end else begin
                                ph_q   <= PH_REGDAT;
                                rsel_q <= byte_val[7:4];
                            end
                        end
                        PH_REGDAT: ph_q <= PH_SKIP;
                        default: ;
                    endcase
                end
            end
        end
    end

    sercmd_regfile #(
        .NUM_REGS  (NUM_REGS),
        .REG_W     (8),
        .IDX_W     (RSEL_W),
        .REG0_INIT (REG0_INIT)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (byte_done && (ph_q == PH_REGDAT)),
        .wr_idx    (rsel_q),
        .wr_data   (byte_val),
        .regs_flat (cfg_regs)
    );

    sercmd_pktbuf #(
        .PKT_BYTES (PKT_BYTES),
        .SYM_W     (SYM_W)
    ) u_pkt (
        .clk      (clk),
        .rst      (rst),
        .start    (byte_done && (ph_q == PH_CTRL) && byte_val[0]),
        .byte_we  (byte_done && (ph_q == PH_PKT)),
        .sym_in   (byte_val[7:8-SYM_W]),
        .commit   (ce_fall && (ph_q == PH_PKT)),
        .pkt_flat (pkt_data),
        .pkt_wr   (pkt_wr)
    );

    sercmd_rdshift #(
        .READ_BYTES (PKT_BYTES),
        .IDX_W      (IDX_W)
    ) u_rd (
        .clk        (clk),
        .rst        (rst),
        .clear      (ce_rise),
        .load_first (byte_done && (ph_q == PH_ADDR) && (byte_val == RD_ADDR)),
        .active     (ev.ce && (ph_q == PH_READ)),
        .sck_rise   (ev.sck_rise),
        .sck_fall   (ev.sck_fall),
        .rd_data    (rd_data),
        .rd_idx     (rd_idx),
        .sdo_low    (ser_dout_low)
    );

    // R9: framing inactive means the line is let go
    assert_release_off_R9: assert property (@(posedge clk) disable iff (rst)
        !ev.ce |-> !ser_dout_low)
        else $error("data line driven with chip-enable low");

    // R9: only a read transfer may pull the line
    assert_read_only_R9: assert property (@(posedge clk) disable iff (rst)
        ser_dout_low |-> (ph_q == PH_READ))
        else $error("data line driven outside a read");

endmodule

// File: tb/sercmd_port_tb.sv
module sercmd_port_tb;

    localparam int         CLK_PERIOD = 10;
    localparam int         HALF       = 6;
    localparam int         NREG       = 14;
    localparam int         NPKT       = 19;
    localparam int         WATCHDOG   = 150000;
    localparam logic [7:0] FLAG_BYTE  = 8'hA6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ser_ce = 1'b0;
    logic              ser_clk = 1'b0;
    logic              ser_din = 1'b0;
    logic              ser_dout_low;
    logic [NREG*8-1:0] cfg_regs;
    logic [NPKT*6-1:0] pkt_data;
    logic              pkt_wr;
    logic [4:0]        rd_idx;
    logic [7:0]        rd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rd_data = (rd_idx == 5'd0) ? FLAG_BYTE : 8'(32'(rd_idx) * 37 + 5);

    sercmd_port u_dut (
        .clk          (clk),
        .rst          (rst),
        .ser_ce       (ser_ce),
        .ser_clk      (ser_clk),
        .ser_din      (ser_din),
        .ser_dout_low (ser_dout_low),
        .cfg_regs     (cfg_regs),
        .pkt_data     (pkt_data),
        .pkt_wr       (pkt_wr),
        .rd_idx       (rd_idx),
        .rd_data      (rd_data)
    );

    int         n_cmp = 0;
    int         n_bad = 0;
    int         n_pulse = 0;
    bit         done = 1'b0;
    bit         mon_on = 1'b0;
    bit         may_drive = 1'b0;
    bit         exp_pulse = 1'b0;
    bit         pkt_full = 1'b0;
    logic [7:0] exp_regs [NREG];
    logic [5:0] exp_sym  [NPKT];
    logic [7:0] rx;

    function automatic logic [NREG*8-1:0] exp_reg_flat();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = exp_regs[i];
        return v;
    endfunction

    function automatic logic [NPKT*6-1:0] exp_pkt_flat();
        logic [NPKT*6-1:0] v;
        for (int i = 0; i < NPKT; i++) v[i*6 +: 6] = exp_sym[i];
        return v;
    endfunction

    function automatic logic [7:0] exp_rd(input int k);
        if (k == 0)   return FLAG_BYTE;
        if (k < NPKT) return 8'(k * 37 + 5);
        return 8'hFF;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model compared on every clock
    always @(negedge clk) begin
        if (mon_on) begin
            chk(cfg_regs == exp_reg_flat(), "R1 register file", cfg_regs, exp_reg_flat());
            chk(pkt_wr == exp_pulse, "R5 commit strobe", pkt_wr, exp_pulse);
            if (pkt_wr && exp_pulse)
                chk(pkt_data == exp_pkt_flat(), "R5 packet contents", pkt_data, exp_pkt_flat());
            if (!may_drive)
                chk(ser_dout_low == 1'b0, "R9 line released", ser_dout_low, 1'b0);
        end
    end

    always @(posedge clk) if (!rst && pkt_wr) n_pulse++;

    task automatic ce_on();
        @(negedge clk) ser_ce = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic ce_off();
        @(negedge clk) ser_ce = 1'b0;
        repeat (2) @(posedge clk);
        may_drive = 1'b0;
        @(posedge clk);
        if (pkt_full) exp_pulse = 1'b1;
        @(posedge clk);
        exp_pulse = 1'b0;
        pkt_full  = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    // act: 0 none, 1 register update in model, 2 read begins
    task automatic xfer(input logic [7:0] tx, output logic [7:0] got,
                        input int act, input int arg);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) ser_din = tx[i];
            repeat (HALF-1) @(negedge clk);
            got[i]  = ~ser_dout_low;
            ser_clk = 1'b1;
            if (i == 7) begin
                repeat (3) @(posedge clk);
                if (act == 1 && arg < NREG) exp_regs[arg] = tx;
                if (act == 2) may_drive = 1'b1;
                repeat (HALF-2) @(negedge clk);
            end else begin
                repeat (HALF) @(negedge clk);
            end
            ser_clk = 1'b0;
        end
    endtask

    task automatic wr_reg(input int n, input logic [7:0] d, input int extra);
        logic [7:0] junk;
        ce_on();
        xfer(8'hF4, junk, 0, 0);
        xfer({4'(n), 4'b0000}, junk, 0, 0);
        xfer(d, junk, 1, n);
        for (int e = 0; e < extra; e++) xfer(8'(8'h5A + e * 17), junk, 0, 0);
        ce_off();
    endtask

    task automatic wr_pkt(input int nbytes);
        logic [7:0] junk;
        logic [7:0] b;
        ce_on();
        xfer(8'hF4, junk, 0, 0);
        xfer(8'h31, junk, 0, 0);
        for (int k = 0; k < nbytes; k++) begin
            b = 8'(k * 29 + 3 + nbytes);
            if (k < NPKT) exp_sym[k] = b[7:2];
            xfer(b, junk, 0, 0);
        end
        pkt_full = (nbytes >= NPKT);
        ce_off();
    endtask

    task automatic rd_stream(input int nbytes);
        logic [7:0] junk;
        ce_on();
        xfer(8'hF5, junk, 2, 0);
        for (int k = 0; k < nbytes; k++) begin
            xfer(8'h00, rx, 0, 0);
            if (k < NPKT) chk(rx == exp_rd(k), "R7 read byte", rx, exp_rd(k));
            else          chk(rx == exp_rd(k), "R8 past end", rx, exp_rd(k));
        end
        ce_off();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int pulses_before;
        logic [7:0] junk;
        for (int i = 0; i < NREG; i++) exp_regs[i] = (i == 0) ? 8'h60 : 8'h00;
        for (int i = 0; i < NPKT; i++) exp_sym[i] = 6'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cfg_regs[7:0] == 8'h60, "R2 reg0 reset", cfg_regs[7:0], 8'h60);
        chk(cfg_regs == exp_reg_flat(), "R2 reset file", cfg_regs, exp_reg_flat());
        chk(ser_dout_low == 1'b0, "R9 reset line", ser_dout_low, 1'b0);
        mon_on = 1'b1;

        // R1: several registers and data patterns
        wr_reg(3, 8'hA5, 0);
        chk(cfg_regs[31:24] == 8'hA5, "R1 reg3", cfg_regs[31:24], 8'hA5);
        wr_reg(0, 8'h81, 0);
        chk(cfg_regs[7:0] == 8'h81, "R1 reg0", cfg_regs[7:0], 8'h81);
        wr_reg(13, 8'h3C, 0);
        chk(cfg_regs[111:104] == 8'h3C, "R1 reg13", cfg_regs[111:104], 8'h3C);
        wr_reg(7, 8'h01, 0);
        wr_reg(12, 8'h80, 0);

        // R3: out-of-range register numbers
        wr_reg(14, 8'hFF, 0);
        wr_reg(15, 8'h77, 0);
        chk(cfg_regs == exp_reg_flat(), "R3 ignored numbers", cfg_regs, exp_reg_flat());

        // R10: only the first data byte counts
        wr_reg(5, 8'h11, 2);
        chk(cfg_regs[47:40] == 8'h11, "R10 first byte only", cfg_regs[47:40], 8'h11);

        // R4: unknown address
        ce_on();
        xfer(8'hF6, junk, 0, 0);
        xfer(8'h30, junk, 0, 0);
        xfer(8'hEE, junk, 0, 0);
        ce_off();
        chk(cfg_regs == exp_reg_flat(), "R4 unknown address", cfg_regs, exp_reg_flat());

        // R5: full packet
        pulses_before = n_pulse;
        wr_pkt(NPKT);
        chk(n_pulse == pulses_before + 1, "R5 one commit", n_pulse, pulses_before + 1);

        // R6: short packet dropped, long packet truncated
        pulses_before = n_pulse;
        wr_pkt(NPKT - 1);
        chk(n_pulse == pulses_before, "R6 short packet", n_pulse, pulses_before);
        wr_pkt(NPKT + 2);
        chk(n_pulse == pulses_before + 1, "R6 long packet", n_pulse, pulses_before + 1);

        // R7 and R8: full read with tail
        rd_stream(NPKT + 2);

        // R9: flag-only read, partial read, then a write
        rd_stream(1);
        rd_stream(3);
        wr_reg(2, 8'h5C, 0);
        chk(cfg_regs[23:16] == 8'h5C, "R9 write after abort", cfg_regs[23:16], 8'h5C);
        repeat (10) @(negedge clk);
        chk(ser_dout_low == 1'b0, "R9 idle line", ser_dout_low, 1'b0);

        mon_on = 1'b0;
        done   = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule